// File: doc/BRIEF.md
# Chained DMA Channel Controller

This block is one DMA channel that moves words between memory and a single peripheral. Software sets it up through three 32-bit registers: a control/status word, a live address and a live byte count. The channel splits the transfer into memory bursts of a selectable length. It advances the address and reduces the byte count on every word. When the count reaches zero it flags terminal count.

The address and count registers each have a hidden shadow, the "next" pair. A control bit decides whether a write goes to the live register or to its shadow. A transfer can therefore be queued while another one is still running. At terminal count the channel copies the queued pair into the live registers and carries on without software help. It raises an interrupt on terminal count or on a memory error, and each interrupt source can be masked.

The memory side is a burst command port. The command (address, length, direction) is offered with `mem_valid`, and the channel keeps it unchanged until the memory accepts it with `mem_ready`. That is the only back-pressure point on the command. After acceptance, the memory returns one `mem_beat` pulse for each word it completes. It may insert idle cycles between beats, and it may end the burst early by raising `mem_err`. The peripheral raises `dev_req` while it can take part in a burst, and it gets one `dev_ack` pulse per word moved.

Top module: `dma_chain_chan`

## Requirements
- R1: After hardware reset the control/status word reads 0xC000_0000 (ID field 0xC in bits 31:28, every other bit 0), the address and count read 0, `irq` is 0 and `mem_valid` is 0.
- R2: Offset 0 is the control/status word, offset 4 the address and offset 8 the byte count. Reads of 4 and 8 always return the live registers. Bits 1:0 of every address or count write are stored as 0.
- R3: While the chain-select bit (bit 24) is 1, writes to offsets 4 and 8 update only the shadow pair and leave the live registers unchanged. A shadow-address write sets bit 27, and a live-address write sets bit 26.
- R4: Burst code bits 19:18 select 4 words (00), 8 words (01), 1 word (10) or 16 words (11). While counting is enabled, each burst is the smaller of that size and the words remaining.
- R5: `mem_valid` stays high with `mem_addr` and `mem_len` unchanged until `mem_ready`. No burst starts while `dev_req` is low. `mem_write` equals direction bit 8 (1 = device to memory). `dev_ack` pulses once per word.
- R6: Each completed word adds 4 to the address. The count drops by 4 per word only while the count-enable bit (bit 13) is 1; otherwise it is unchanged.
- R7: When counting brings the count to 0, terminal-count bit 14 is set. Writing 1 to bit 14 clears it. With no shadow address queued, run status bit 25 clears and the channel issues no further bursts.
- R8: At terminal count with bit 27 set, the shadow address and count move into the live registers, bit 27 clears and bursts continue from the new address.
- R9: Interrupt bit 0 and `irq` are 1 when interrupt enable (bit 4) is 1 and either terminal count is set with its mask bit 23 at 0, or error is set with its mask bit 22 at 0.
- R10: `mem_err` during a burst ends that burst and sets error bit 1, which is cleared by writing 1 to it. Unless bit 22 is 1, the error also clears bit 25 and stops the channel.
- R11: Writing 1 to bit 7 clears all channel state and holds it cleared. While held, writes to offsets 4 and 8 are ignored, and writes to offset 0 change only bit 7.
- R12: Writing offset 0 with bit 9 at 1 sets run status bit 25. Cycle-pending bit 10 reads 1 from the moment a burst command is raised until its last word or error.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the register at `reg_addr` |
| irq | output | 1 | Interrupt request (copy of bit 0) |
| mem_valid | output | 1 | Burst command valid |
| mem_ready | input | 1 | Burst command accepted |
| mem_write | output | 1 | 1 = write memory (device to memory) |
| mem_addr | output | 32 | Burst start byte address |
| mem_len | output | 5 | Burst length in words (1 to 16) |
| mem_beat | input | 1 | One word of the accepted burst completed |
| mem_err | input | 1 | Memory error, ends the burst |
| dev_req | input | 1 | Peripheral ready to transfer |
| dev_ack | output | 1 | Word transferred for the peripheral |

## Verification
The bench builds the channel with its default parameters: 4-byte words, ID 0xC and 5-bit burst lengths. With these values all four burst codes are exercised, including a 16-word burst, and counts that are not a multiple of the burst size produce shortened final bursts. Byte counts of up to 80 are enough to reach partial final bursts, the chain hand-over, an error in the middle of a burst and command back-pressure, all within a few hundred cycles each.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int REG_W = 32;
  localparam int LEN_W = 5;
  localparam int MAX_BURST = 16;

  localparam logic [3:0] OFS_CSR = 4'h0;
  localparam logic [3:0] OFS_ADR = 4'h4;
  localparam logic [3:0] OFS_CNT = 4'h8;

  // control/status bit positions
  localparam int B_IPEND = 0;
  localparam int B_EPEND = 1;
  localparam int B_IEN   = 4;
  localparam int B_SRST  = 7;
  localparam int B_DIR   = 8;
  localparam int B_EN    = 9;
  localparam int B_CYC   = 10;
  localparam int B_ENCNT = 13;
  localparam int B_TC    = 14;
  localparam int B_BLO   = 18;
  localparam int B_DERR  = 22;
  localparam int B_TCMSK = 23;
  localparam int B_CHSEL = 24;
  localparam int B_ON    = 25;
  localparam int B_ALD   = 26;
  localparam int B_NALD  = 27;
  localparam int B_IDLO  = 28;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_BEAT} seq_state_t;

  function automatic logic [LEN_W-1:0] burst_words(input logic [1:0] code);
    case (code)
      2'b00:   return LEN_W'(4);
      2'b01:   return LEN_W'(8);
      2'b10:   return LEN_W'(1);
      default: return LEN_W'(16);
    endcase
  endfunction
endpackage

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int         WORD_BYTES = 4,
  parameter logic [3:0] DEV_ID     = 4'hC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             beat_stb,
  input  logic             err_stb,
  input  logic             cyc_pend,
  output logic [REG_W-1:0] cur_addr,
  output logic [LEN_W-1:0] next_len,
  output logic             run,
  output logic             dir,
  output logic             irq
);
  localparam int LSB = $clog2(WORD_BYTES);
  localparam logic [REG_W-1:0] STEP = REG_W'(WORD_BYTES);

  logic ien, srst, dir_q, en_q, encnt, derr, tcmsk, chsel, on_q, ald, nald, tc, ep;
  logic [1:0] bsz;
  logic [REG_W-1:0] adr, nadr, cnt, ncnt;

  logic wr_csr, wr_adr, wr_cnt, last_beat, ipend;
  logic [REG_W-1:0] wr_aligned, words;
  logic [LEN_W-1:0] bw;

  assign wr_csr     = reg_we && (reg_addr == OFS_CSR);
  assign wr_adr     = reg_we && (reg_addr == OFS_ADR);
  assign wr_cnt     = reg_we && (reg_addr == OFS_CNT);
  assign wr_aligned = reg_wdata & ~(STEP - 1'b1);
  assign last_beat  = beat_stb && encnt && (cnt == STEP);
  assign ipend      = ien && ((tc && !tcmsk) || (ep && !derr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ien, srst, dir_q, en_q, encnt, derr, tcmsk, chsel, on_q, ald, nald, tc, ep} <= '0;
      bsz <= '0; adr <= '0; nadr <= '0; cnt <= '0; ncnt <= '0;
    end else if (srst) begin
      if (wr_csr) srst <= reg_wdata[B_SRST];
    end else if (wr_csr && reg_wdata[B_SRST]) begin
      {ien, dir_q, en_q, encnt, derr, tcmsk, chsel, on_q, ald, nald, tc, ep} <= '0;
      bsz <= '0; adr <= '0; nadr <= '0; cnt <= '0; ncnt <= '0;
      srst <= 1'b1;
    end else begin
      if (wr_csr) begin
        ien   <= reg_wdata[B_IEN];
        dir_q <= reg_wdata[B_DIR];
        en_q  <= reg_wdata[B_EN];
        on_q  <= reg_wdata[B_EN];
        encnt <= reg_wdata[B_ENCNT];
        bsz   <= reg_wdata[B_BLO +: 2];
        derr  <= reg_wdata[B_DERR];
        tcmsk <= reg_wdata[B_TCMSK];
        chsel <= reg_wdata[B_CHSEL];
        if (reg_wdata[B_TC])    tc <= 1'b0;
        if (reg_wdata[B_EPEND]) ep <= 1'b0;
      end
      if (wr_adr) begin
        if (chsel) begin nadr <= wr_aligned; nald <= 1'b1; end
        else       begin adr  <= wr_aligned; ald  <= 1'b1; end
      end
      if (wr_cnt) begin
        if (chsel) ncnt <= wr_aligned;
        else       cnt  <= wr_aligned;
      end
      if (beat_stb) begin
        adr <= adr + STEP;
        if (encnt) cnt <= cnt - STEP;
        if (last_beat) begin
          tc <= 1'b1;
          if (nald) begin
            adr <= nadr; cnt <= ncnt; nald <= 1'b0; ald <= 1'b1;
          end else begin
            on_q <= 1'b0;
          end
        end
      end
      if (err_stb) begin
        ep <= 1'b1;
        if (!derr) on_q <= 1'b0;
      end
    end
  end

  // burst sizing: shorten the last burst to the words left
  assign bw    = burst_words(bsz);
  assign words = cnt >> LSB;
  always_comb begin
    if (encnt && (words < REG_W'(bw))) next_len = words[LEN_W-1:0];
    else                               next_len = bw;
  end

  assign run      = on_q && !srst && !(encnt && (cnt == '0));
  assign cur_addr = adr;
  assign dir      = dir_q;
  assign irq      = ipend;

  logic [REG_W-1:0] csr;
  always_comb begin
    csr = '0;
    csr[B_IDLO +: 4] = DEV_ID;
    csr[B_NALD]  = nald;
    csr[B_ALD]   = ald;
    csr[B_ON]    = on_q;
    csr[B_CHSEL] = chsel;
    csr[B_TCMSK] = tcmsk;
    csr[B_DERR]  = derr;
    csr[B_BLO +: 2] = bsz;
    csr[B_TC]    = tc;
    csr[B_ENCNT] = encnt;
    csr[B_CYC]   = cyc_pend;
    csr[B_EN]    = en_q;
    csr[B_DIR]   = dir_q;
    csr[B_SRST]  = srst;
    csr[B_IEN]   = ien;
    csr[B_EPEND] = ep;
    csr[B_IPEND] = ipend;
  end

  always_comb begin
    case (reg_addr)
      OFS_CSR: reg_rdata = csr;
      OFS_ADR: reg_rdata = adr;
      OFS_CNT: reg_rdata = cnt;
      default: reg_rdata = '0;
    endcase
  end

  // R8: chained hand-over loads the shadow pair
  p_chain_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && nald && !srst && !reg_we) |=> (adr == $past(nadr) && cnt == $past(ncnt) && !nald && on_q));
  // R7: terminal count with nothing queued stops the channel
  p_tc_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && !nald && !srst && !reg_we) |=> (tc && !on_q && !run));
  // R10: an unmasked error stops the channel
  p_err_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_stb && !derr && !srst && !reg_we) |=> (ep && !on_q));
  // R11: address writes are ignored during soft reset
  p_srst_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (srst && wr_adr) |=> (adr == '0 && nadr == '0));
  // R9: terminal count interrupt when enabled and unmasked
  p_tc_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_beat && ien && !tcmsk && !srst && !reg_we) |=> irq);
endmodule

// File: rtl/dmac_seq.sv
module dmac_seq
  import dmac_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             dev_req,
  input  logic [LEN_W-1:0] next_len,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic [LEN_W-1:0] mem_len,
  input  logic             mem_beat,
  input  logic             mem_err,
  output logic             beat_stb,
  output logic             err_stb,
  output logic             cyc_pend,
  output logic             dev_ack
);
  seq_state_t st;
  logic [LEN_W-1:0] left, len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; left <= '0; len_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (run && dev_req) begin
          st <= S_REQ; len_q <= next_len; left <= next_len;
        end
        S_REQ: if (mem_ready) st <= S_BEAT;
        S_BEAT: begin
          if (mem_beat) left <= left - 1'b1;
          if (mem_err || (mem_beat && left == LEN_W'(1))) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_valid = (st == S_REQ);
  assign mem_len   = len_q;
  assign beat_stb  = (st == S_BEAT) && mem_beat;
  assign err_stb   = (st == S_BEAT) && mem_err;
  assign cyc_pend  = (st != S_IDLE);
  assign dev_ack   = beat_stb;

  // R5: command held stable under back-pressure
  p_cmd_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_len)));
  // R4: burst length within 1..MAX_BURST
  p_len_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> (mem_len != '0 && mem_len <= LEN_W'(MAX_BURST)));
  // R12: a new command only follows an idle cycle
  p_cmd_after_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_valid) |-> $past(!cyc_pend));
endmodule

// File: rtl/dma_chain_chan.sv
module dma_chain_chan
  import dmac_pkg::*;
#(
  parameter int         WORD_BYTES = 4,
  parameter logic [3:0] DEV_ID     = 4'hC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [3:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  output logic             mem_valid,
  input  logic             mem_ready,
  output logic             mem_write,
  output logic [REG_W-1:0] mem_addr,
  output logic [LEN_W-1:0] mem_len,
  input  logic             mem_beat,
  input  logic             mem_err,
  input  logic             dev_req,
  output logic             dev_ack
);
  logic beat_stb, err_stb, cyc_pend, run;
  logic [LEN_W-1:0] next_len;

  dmac_regs #(.WORD_BYTES(WORD_BYTES), .DEV_ID(DEV_ID)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .beat_stb(beat_stb),
    .err_stb(err_stb), .cyc_pend(cyc_pend), .cur_addr(mem_addr),
    .next_len(next_len), .run(run), .dir(mem_write), .irq(irq)
  );

  dmac_seq u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .dev_req(dev_req),
    .next_len(next_len), .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_len(mem_len), .mem_beat(mem_beat), .mem_err(mem_err),
    .beat_stb(beat_stb), .err_stb(err_stb), .cyc_pend(cyc_pend),
    .dev_ack(dev_ack)
  );

  // R6: without a beat the address does not move
  p_addr_still_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_ack && !reg_we) |=> $stable(mem_addr));
endmodule

// File: tb/dma_chain_chan_bench.sv
module dma_chain_chan_bench;
  import dmac_pkg::*;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic reg_we = 0; logic [3:0] reg_addr = 0; logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata; logic irq, mem_valid, mem_write, dev_ack;
  logic mem_ready = 0, mem_beat = 0, mem_err = 0, dev_req = 1;
  logic [31:0] mem_addr; logic [4:0] mem_len;

  dma_chain_chan u_dma_chain_chan (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_write(mem_write),
    .mem_addr(mem_addr), .mem_len(mem_len), .mem_beat(mem_beat),
    .mem_err(mem_err), .dev_req(dev_req), .dev_ack(dev_ack)
  );

  localparam logic [31:0] C_EN = 32'h1 << 9, C_CNT = 32'h1 << 13, C_IEN = 32'h1 << 4;
  localparam logic [31:0] C_TC = 32'h1 << 14, C_ERR = 32'h1 << 1, C_CH = 32'h1 << 24;
  localparam logic [31:0] C_TMSK = 32'h1 << 23, C_DERR = 32'h1 << 22, C_SRST = 32'h1 << 7;
  localparam logic [31:0] C_DIR = 32'h1 << 8;

  typedef struct packed {
    logic [1:0] code; logic [15:0] cnt; logic [7:0] nb; logic [4:0] l0; logic [4:0] ll;
  } vec_t;
  localparam vec_t VEC [5] = '{
    '{2'b00, 16'd32, 8'd2, 5'd4,  5'd4},
    '{2'b01, 16'd40, 8'd2, 5'd8,  5'd2},
    '{2'b10, 16'd12, 8'd3, 5'd1,  5'd1},
    '{2'b11, 16'd24, 8'd1, 5'd6,  5'd6},
    '{2'b11, 16'd80, 8'd2, 5'd16, 5'd4}
  };

  int checks = 0, errors = 0;
  bit done = 0;

  // memory responder
  int beat_left = 0, beats_done = 0, bursts = 0, err_at = -1, acks = 0;
  bit hold_rdy = 0, pv = 0;
  logic [4:0] plen = 0; logic [31:0] paddr = 0;
  logic [31:0] b_addr [8]; int b_len [8];

  always @(negedge clk) begin
    if (mem_beat) begin
      beats_done++; beat_left--;
      if (mem_err) beat_left = 0;
    end
    if (pv && mem_ready) begin
      if (bursts < 8) begin b_addr[bursts] = paddr; b_len[bursts] = int'(plen); end
      bursts++; beat_left = int'(plen);
    end
    mem_ready = mem_valid && !hold_rdy;
    mem_beat  = (beat_left > 0);
    mem_err   = mem_beat && (beats_done + 1 == err_at);
    pv = mem_valid; plen = mem_len; paddr = mem_addr;
  end

  always @(posedge clk) if (dev_ack) acks++;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic clr_log();
    bursts = 0; beats_done = 0; acks = 0;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      rd(OFS_CSR, v);
      if (!v[25] && !v[10]) return;
    end
    chk("R7 completion timeout", 32'd1, 32'd0);
  endtask

  task automatic prog(logic [31:0] a, logic [31:0] c);
    wr(OFS_CSR, C_TC | C_ERR);
    wr(OFS_ADR, a);
    wr(OFS_CNT, c);
    clr_log();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, a;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(OFS_CSR, v); chk("R1 csr reset", v, 32'hC000_0000);
    rd(OFS_ADR, v); chk("R1 addr reset", v, 0);
    rd(OFS_CNT, v); chk("R1 count reset", v, 0);
    chk("R1 irq reset", {31'd0, irq}, 0);
    chk("R1 valid reset", {31'd0, mem_valid}, 0);

    // R2 low bits dropped
    wr(OFS_CNT, 32'h13); rd(OFS_CNT, v); chk("R2 count align", v, 32'h10);

    // vector table: burst sizing, stepping, terminal count
    for (int i = 0; i < 5; i++) begin
      a = 32'h1000_0000 + 32'(i) * 32'h100;
      prog(a, 32'(VEC[i].cnt));
      wr(OFS_CSR, C_EN | C_CNT | C_IEN | (32'(VEC[i].code) << 18) | (i[0] ? C_DIR : 0));
      chk("R5 direction", {31'd0, mem_write}, {31'd0, i[0]});
      wait_done();
      chk("R4 burst count", 32'(bursts), 32'(VEC[i].nb));
      chk("R4 first length", 32'(b_len[0]), 32'(VEC[i].l0));
      chk("R4 last length", 32'(b_len[VEC[i].nb - 1]), 32'(VEC[i].ll));
      chk("R5 first addr", b_addr[0], a);
      chk("R5 ack count", 32'(acks), 32'(VEC[i].cnt) / 4);
      rd(OFS_ADR, v); chk("R6 final addr", v, a + 32'(VEC[i].cnt));
      rd(OFS_CNT, v); chk("R6 final count", v, 0);
      rd(OFS_CSR, v);
      chk("R7 tc set", {31'd0, v[14]}, 1);
      chk("R7 run cleared", {31'd0, v[25]}, 0);
      chk("R9 irq on tc", {31'd0, irq}, 1);
    end

    // R7 / R9 write-one-to-clear terminal count
    wr(OFS_CSR, C_TC); rd(OFS_CSR, v);
    chk("R7 tc cleared", {31'd0, v[14]}, 0);
    chk("R9 irq cleared", {31'd0, irq}, 0);

    // R9 masked terminal-count interrupt
    prog(32'h4000, 8);
    wr(OFS_CSR, C_EN | C_CNT | C_IEN | C_TMSK);
    wait_done(); rd(OFS_CSR, v);
    chk("R9 tc under mask", {31'd0, v[14]}, 1);
    chk("R9 irq masked", {31'd0, irq}, 0);

    // R3 / R8 chained transfer
    wr(OFS_CSR, C_TC | C_CNT);
    wr(OFS_ADR, 32'h2000); wr(OFS_CNT, 16);
    wr(OFS_CSR, C_CNT | C_CH);
    wr(OFS_ADR, 32'h3000); wr(OFS_CNT, 8);
    rd(OFS_ADR, v); chk("R3 live addr kept", v, 32'h2000);
    rd(OFS_CNT, v); chk("R3 live count kept", v, 16);
    rd(OFS_CSR, v);
    chk("R3 next loaded flag", {31'd0, v[27]}, 1);
    chk("R3 live loaded flag", {31'd0, v[26]}, 1);
    clr_log();
    wr(OFS_CSR, C_EN | C_CNT | C_CH | C_IEN);
    wait_done();
    chk("R8 bursts", 32'(bursts), 2);
    chk("R8 second addr", b_addr[1], 32'h3000);
    chk("R8 words", 32'(acks), 6);
    rd(OFS_ADR, v); chk("R8 final addr", v, 32'h3008);
    rd(OFS_CNT, v); chk("R8 final count", v, 0);
    rd(OFS_CSR, v); chk("R8 next flag cleared", {31'd0, v[27]}, 0);

    // R5 / R12 back-pressure on the command
    hold_rdy = 1;
    prog(32'h5000, 8);
    wr(OFS_CSR, C_EN | C_CNT);
    repeat (5) @(negedge clk);
    chk("R5 valid held", {31'd0, mem_valid}, 1);
    chk("R5 addr held", mem_addr, 32'h5000);
    chk("R5 len held", {27'd0, mem_len}, 2);
    rd(OFS_CSR, v); chk("R12 cycle pending", {31'd0, v[10]}, 1);
    hold_rdy = 0;
    wait_done();
    rd(OFS_ADR, v); chk("R5 after release", v, 32'h5008);

    // R5 / R12 peripheral not requesting
    dev_req = 0;
    prog(32'h6000, 8);
    wr(OFS_CSR, C_EN | C_CNT);
    repeat (10) @(negedge clk);
    chk("R5 no valid without dev_req", {31'd0, mem_valid}, 0);
    rd(OFS_CSR, v); chk("R12 run set", {31'd0, v[25]}, 1);
    dev_req = 1;
    wait_done();
    chk("R5 words after dev_req", 32'(acks), 2);

    // R6 counting disabled
    prog(32'h7000, 8);
    wr(OFS_CSR, C_EN | (32'h2 << 18));
    repeat (20) @(negedge clk);
    wr(OFS_CSR, 0);
    wait_done();
    rd(OFS_CNT, v); chk("R6 count frozen", v, 8);
    rd(OFS_ADR, v); chk("R6 addr advanced", v, 32'h7000 + 32'(beats_done) * 4);
    chk("R6 beats occurred", {31'd0, beats_done > 0}, 1);

    // R10 error stops the channel
    err_at = 2;
    prog(32'h8000, 32);
    wr(OFS_CSR, C_EN | C_CNT | C_IEN);
    wait_done();
    rd(OFS_CSR, v);
    chk("R10 error flag", {31'd0, v[1]}, 1);
    chk("R10 stopped", {31'd0, v[25]}, 0);
    chk("R10 irq on error", {31'd0, irq}, 1);
    rd(OFS_CNT, v); chk("R10 count at error", v, 24);
    wr(OFS_CSR, C_ERR); rd(OFS_CSR, v);
    chk("R10 error cleared", {31'd0, v[1]}, 0);

    // R10 error masked: continues, no interrupt
    clr_log(); err_at = 2;
    wr(OFS_CSR, C_TC); wr(OFS_ADR, 32'h9000); wr(OFS_CNT, 16);
    wr(OFS_CSR, C_EN | C_CNT | C_IEN | C_TMSK | C_DERR);
    wait_done();
    err_at = -1;
    rd(OFS_CSR, v); chk("R10 masked flag", {31'd0, v[1]}, 1);
    chk("R10 masked irq", {31'd0, irq}, 0);
    chk("R10 burst split", 32'(bursts), 2);
    rd(OFS_CNT, v); chk("R10 masked completes", v, 0);

    // R11 soft reset
    wr(OFS_CSR, C_ERR | C_TC);
    wr(OFS_ADR, 32'hA000);
    wr(OFS_CSR, C_SRST | C_EN | C_IEN);
    rd(OFS_CSR, v); chk("R11 held csr", v, 32'hC000_0080);
    rd(OFS_ADR, v); chk("R11 addr cleared", v, 0);
    wr(OFS_ADR, 32'hB000);
    rd(OFS_ADR, v); chk("R11 addr write ignored", v, 0);
    wr(OFS_CSR, C_EN);
    rd(OFS_CSR, v); chk("R11 release only", v, 32'hC000_0000);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule